// File: doc/BRIEF.md
# I2C Bus Event Monitor

This block listens passively to a two-wire serial bus. It samples the clock and data lines, which must already be synchronized to the system clock, once per system clock. It turns what it sees into a stream of typed bus events: start, repeated start, stop, address (read or write), data (read or write), ACK and NACK. Address and data events carry the byte seen on the bus. The block never drives the bus.

The direction bit at the end of the address byte is kept. Every later data byte is tagged as a read or a write until the transfer closes. A configuration input chooses how the address is reported: as a 7-bit value with the direction bit removed, or as the raw 8-bit byte. Each event is presented for one clock as a valid strobe, a 4-bit event code and an 8-bit value. A downstream logger or protocol checker can consume this stream directly.

Top module: `i2cmon_top`

## Requirements
- R1: A falling SDA while SCL is high, with no transfer open, gives event code 0 (start) with data 0 and opens a transfer.
- R2: The same condition while a transfer is open (no stop since the last start) gives code 1 (repeated start) with data 0. The next byte is taken as a new address.
- R3: A rising SDA while SCL is high closes an open transfer with code 2 (stop) and data 0. When no transfer is open, this condition and any SCL pulses produce no event.
- R4: Bits are taken on SCL rising edges, most significant first. After the eighth bit of the first byte following a start, an address event is given. Byte bit 0 = 1 gives code 5 (address read) and bit 0 = 0 gives code 6 (address write).
- R5: When addr_raw_i is 0, the address value is the byte shifted right by one (0xA2 is reported as 0x51). When addr_raw_i is 1, it is the full byte.
- R6: The ninth SCL rise after a byte gives code 3 (ACK) if SDA is 0 or code 4 (NACK) if SDA is 1, with data 0. Collection then continues with a data byte.
- R7: Data bytes give code 7 (data read) when the last address had bit 0 = 1, and code 8 (data write) otherwise, carrying the full byte. Any number of data bytes may follow one address.
- R8: Every event is a single-clock strobe. It is registered on the clock edge at which the condition is first sampled, and its code is never above 8.
- R9: During reset, no event is output. The previous line levels are taken as high, so SDA low with SCL high at the first sample after reset is reported as a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| addr_raw_i | input | 1 | 1: report the raw address byte; 0: report it shifted to 7 bits |
| evt_valid_o | output | 1 | One-clock event strobe |
| evt_code_o | output | 4 | Event code (0 to 8) |
| evt_data_o | output | 8 | Byte value of address and data events, otherwise 0 |

## Verification
Each event appears after exactly one register stage. Its strobe rises just after the system clock edge at which the new line levels are first sampled, and it stays high for that one cycle only. The bench changes the lines only on falling clock edges and holds each level for four clocks. A monitor records the code and value of every strobe on the falling edge after it rises, and it also flags any strobe that lasts two cycles. The recorded order is then compared against the sequence expected for each transfer. The reset case is checked on the first cycle after reset is released, because that is when a start is due if SDA is held low.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [CODE_W-1:0] {
        EV_START   = 4'd0,
        EV_RSTART  = 4'd1,
        EV_STOP    = 4'd2,
        EV_ACK     = 4'd3,
        EV_NACK    = 4'd4,
        EV_ADDR_RD = 4'd5,
        EV_ADDR_WR = 4'd6,
        EV_DATA_RD = 4'd7,
        EV_DATA_WR = 4'd8
    } ev_code_e;

    typedef struct packed {
        logic              valid;
        ev_code_e          code;
        logic [BYTE_W-1:0] data;
    } ev_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic sda;
    } cond_t;

    typedef enum logic [1:0] {ST_HUNT, ST_ADDR, ST_DATA, ST_ACK} st_e;

    function automatic logic [BYTE_W-1:0] addr_view(input logic [BYTE_W-1:0] b,
                                                    input logic raw);
        return raw ? b : (b >> 1);
    endfunction
endpackage

// File: rtl/i2cmon_cond.sv
module i2cmon_cond
    import i2cmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  scl,
    input  logic  sda,
    output cond_t cond
);
    logic scl_q, sda_q;

    // previous levels start high: bus assumed idle
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        cond.start = scl & sda_q & ~sda;
        cond.stop  = scl & ~sda_q & sda;
        cond.rise  = ~scl_q & scl;
        cond.sda   = sda;
    end

    a_r3_cond_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cond.start && cond.stop));
endmodule

// File: rtl/i2cmon_fsm.sv
module i2cmon_fsm
    import i2cmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cond_t cond,
    input  logic  addr_raw,
    output ev_t   ev
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    st_e               state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] acc_q;
    logic              open_q;
    logic              dir_rd_q;
    logic [BYTE_W-1:0] nb;

    always_comb nb = {acc_q, cond.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HUNT;
            cnt_q    <= '0;
            acc_q    <= '0;
            open_q   <= 1'b0;
            dir_rd_q <= 1'b0;
            ev.valid <= 1'b0;
            ev.code  <= EV_START;
            ev.data  <= '0;
        end else begin
            ev.valid <= 1'b0;
            ev.code  <= EV_START;
            ev.data  <= '0;
            if (cond.start) begin
                ev.valid <= 1'b1;
                ev.code  <= open_q ? EV_RSTART : EV_START;
                open_q   <= 1'b1;
                state_q  <= ST_ADDR;
                cnt_q    <= '0;
                acc_q    <= '0;
            end else if (cond.stop && open_q) begin
                ev.valid <= 1'b1;
                ev.code  <= EV_STOP;
                open_q   <= 1'b0;
                dir_rd_q <= 1'b0;
                state_q  <= ST_HUNT;
            end else if (cond.rise) begin
                case (state_q)
                    ST_ADDR, ST_DATA: begin
                        acc_q <= nb[BYTE_W-2:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            cnt_q    <= '0;
                            state_q  <= ST_ACK;
                            ev.valid <= 1'b1;
                            if (state_q == ST_ADDR) begin
                                dir_rd_q <= nb[0];
                                ev.code  <= nb[0] ? EV_ADDR_RD : EV_ADDR_WR;
                                ev.data  <= addr_view(nb, addr_raw);
                            end else begin
                                ev.code  <= dir_rd_q ? EV_DATA_RD : EV_DATA_WR;
                                ev.data  <= nb;
                            end
                        end
                    end
                    ST_ACK: begin
                        ev.valid <= 1'b1;
                        ev.code  <= cond.sda ? EV_NACK : EV_ACK;
                        state_q  <= ST_DATA;
                        cnt_q    <= '0;
                        acc_q    <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r1_plain_start: assert property (@(posedge clk) disable iff (rst)
        (cond.start && !open_q) |=> (ev.valid && ev.code == EV_START && ev.data == '0));
    a_r2_repeat_start: assert property (@(posedge clk) disable iff (rst)
        (cond.start && open_q) |=> (ev.valid && ev.code == EV_RSTART));
    a_r3_stop_close: assert property (@(posedge clk) disable iff (rst)
        (cond.stop && open_q) |=> (ev.valid && ev.code == EV_STOP && !open_q));
    a_r3_idle_stop: assert property (@(posedge clk) disable iff (rst)
        (cond.stop && !open_q) |=> !ev.valid);
    a_r5_shifted_top: assert property (@(posedge clk) disable iff (rst)
        (cond.rise && !cond.start && !cond.stop && state_q == ST_ADDR && cnt_q == LAST && !addr_raw)
        |=> (ev.valid && ev.data[BYTE_W-1] == 1'b0));
    a_r6_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.code <= EV_NACK) |-> ev.data == '0);
    a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
        ev.valid |-> ev.code <= EV_DATA_WR);
endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_raw_i,
    output logic              evt_valid_o,
    output logic [CODE_W-1:0] evt_code_o,
    output logic [BYTE_W-1:0] evt_data_o
);
    cond_t cond;
    ev_t   ev;

    i2cmon_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl  (scl_i),
        .sda  (sda_i),
        .cond (cond)
    );

    i2cmon_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cond     (cond),
        .addr_raw (addr_raw_i),
        .ev       (ev)
    );

    assign evt_valid_o = ev.valid;
    assign evt_code_o  = ev.code;
    assign evt_data_o  = ev.data;

    a_r9_reset_quiet: assert property (@(posedge clk) rst |=> !evt_valid_o);
endmodule

// File: tb/tb_i2cmon_top.sv
`timescale 1ns/1ps
module tb_i2cmon_top;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic raw = 1'b0;
    logic       evt_valid_o;
    logic [3:0] evt_code_o;
    logic [7:0] evt_data_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [3:0] got_code [64];
    logic [7:0] got_data [64];
    int   got_n = 0;
    int   dbl   = 0;
    logic prev_v = 1'b0;
    int   base  = 0;

    always #4 clk = ~clk;

    i2cmon_top dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .addr_raw_i(raw),
        .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o), .evt_data_o(evt_data_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (evt_valid_o) begin
                if (got_n < 64) begin
                    got_code[got_n] = evt_code_o;
                    got_data[got_n] = evt_data_o;
                end
                got_n = got_n + 1;
                if (prev_v) dbl = dbl + 1;
            end
            prev_v = evt_valid_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ev_chk(input int idx, input int code, input int data, input string req);
        int a;
        int i = base + idx;
        a = (i < got_n && i < 64) ? {20'd0, got_code[i], got_data[i]} : -1;
        chk(a == ((code << 8) | data), req, a, (code << 8) | data);
    endtask

    task automatic count_chk(input int n, input string req);
        chk(got_n - base == n, req, got_n - base, n);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; idle(H);
        scl = 1'b1; idle(H);
        sda = 1'b0; idle(H);
        scl = 1'b0; idle(H);
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    idle(H);
        scl = 1'b1; idle(H);
        scl = 1'b0; idle(H);
    endtask

    task automatic bus_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    endtask

    task automatic bus_stop();
        sda = 1'b0; idle(H);
        scl = 1'b1; idle(H);
        sda = 1'b1; idle(H);
    endtask

    // [18] raw, [17:10] address byte, [9:2] data byte, [1] address NACK, [0] data NACK
    localparam logic [18:0] VEC [4] = '{
        {1'b0, 8'hA2, 8'h3C, 1'b0, 1'b0},
        {1'b1, 8'hA2, 8'h5A, 1'b0, 1'b1},
        {1'b0, 8'h9F, 8'h81, 1'b1, 1'b0},
        {1'b1, 8'hFF, 8'h00, 1'b1, 1'b1}
    };

    initial begin
        // R9: reset with SDA low and SCL high
        sda = 1'b0; scl = 1'b1;
        idle(3);
        chk(evt_valid_o == 1'b0, "R9 quiet in reset", evt_valid_o, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(evt_valid_o == 1'b1 && evt_code_o == 4'd0, "R9 start at first sample",
            {evt_valid_o, evt_code_o}, 5'h10);
        @(posedge clk); #1;
        chk(evt_valid_o == 1'b0, "R8 single-cycle strobe", evt_valid_o, 0);
        idle(H);
        sda = 1'b1; idle(H);   // stop closes it
        ev_chk(0, 0, 0, "R9 start event");
        ev_chk(1, 2, 0, "R3 stop after reset start");
        count_chk(2, "R3 event count");
        base = got_n;

        // R3: stop pattern and SCL pulses with no open transfer
        scl = 1'b0; idle(H);
        sda = 1'b0; idle(H);
        scl = 1'b1; idle(H);
        sda = 1'b1; idle(H);
        scl = 1'b0; idle(H); scl = 1'b1; idle(H);
        count_chk(0, "R3 idle stop ignored");
        base = got_n;

        // table of single transfers: R1 R4 R5 R6 R7
        for (int v = 0; v < 4; v++) begin
            logic [18:0] e;
            int ac, dc, av;
            e   = VEC[v];
            raw = e[18];
            bus_start();
            bus_byte(e[17:10]);
            bus_bit(e[1]);
            bus_byte(e[9:2]);
            bus_bit(e[0]);
            bus_stop();
            idle(H);
            ac = e[10] ? 5 : 6;
            dc = e[10] ? 7 : 8;
            av = e[18] ? int'(e[17:10]) : int'(e[17:11]);
            ev_chk(0, 0, 0, "R1 plain start");
            ev_chk(1, ac, av, "R4 R5 address event");
            ev_chk(2, e[1] ? 4 : 3, 0, "R6 address acknowledge");
            ev_chk(3, dc, int'(e[9:2]), "R7 data event");
            ev_chk(4, e[0] ? 4 : 3, 0, "R6 data acknowledge");
            ev_chk(5, 2, 0, "R3 stop");
            count_chk(6, "R8 events per transfer");
            base = got_n;
        end

        // R2: repeated start, read with two data bytes
        raw = 1'b0;
        bus_start();
        bus_byte(8'hA0); bus_bit(1'b0);
        bus_start();
        bus_byte(8'hA1); bus_bit(1'b0);
        bus_byte(8'h12); bus_bit(1'b0);
        bus_byte(8'h34); bus_bit(1'b1);
        bus_stop();
        idle(H);
        ev_chk(0, 0, 0, "R1 start");
        ev_chk(1, 6, 8'h50, "R4 address write");
        ev_chk(2, 3, 0, "R6 ack");
        ev_chk(3, 1, 0, "R2 repeated start");
        ev_chk(4, 5, 8'h50, "R4 address read after repeat");
        ev_chk(5, 3, 0, "R6 ack");
        ev_chk(6, 7, 8'h12, "R7 first read byte");
        ev_chk(7, 3, 0, "R6 ack");
        ev_chk(8, 7, 8'h34, "R7 second read byte");
        ev_chk(9, 4, 0, "R6 nack");
        ev_chk(10, 2, 0, "R3 stop");
        count_chk(11, "R2 event count");
        chk(dbl == 0, "R8 no stretched strobe", dbl, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule